// File: doc/BRIEF.md
# Transmit Descriptor Ring Manager

This block keeps a circular ring of transmit descriptors in on-chip registers and queues outgoing frames for a DMA consumer. Every descriptor carries four 32-bit words: a status word whose top bit marks consumer ownership, a control word with segment flags and the frame length, the frame buffer address, and a link pointer to the next descriptor in the ring.

Software offers a frame length and buffer address on a valid/ready submit port. The manager picks the first descriptor at or after its fill pointer that the consumer does not own. It pads short frames to the minimum length, writes the control word and the buffer address, and sets ownership. One cycle later it pulses a poll-demand strobe. The consumer reads descriptors through a combinational read port. When a frame is done, it writes completion status, which hands the descriptor back in the same cycle.

Top module: `txring_mgr`

## Requirements
- R1: After synchronous reset every descriptor has status 0x00000000, control 0x01000000 and buffer address 0, `sub_ready` is 1 and `poll_demand` is 0.
- R2: An accepted submit (`sub_valid` and `sub_ready` both 1 at a rising edge) leaves the chosen descriptor with status 0x80000000, control 0xE1000000 ORed with the stored length in bits 10:0, and buffer address equal to `sub_addr`.
- R3: A submitted length below 60 is stored as 60. A length of 60 or more is stored unchanged.
- R4: `poll_demand` is 1 for exactly the one cycle that follows each accepted submit, and 0 in every other cycle.
- R5: Straight after reset, the first accepted submit fills slot 0. While no slot is skipped, later submits fill successive slots and wrap from 15 to 0.
- R6: A submit fills the first descriptor, searching forward circularly from the fill pointer, whose status bit 31 is 0. Slots owned by the consumer are skipped. The fill pointer then moves to the slot after the one filled.
- R7: When all 16 descriptors are owned, `sub_ready` is 0. A `sub_valid` in that state changes no descriptor and raises no `poll_demand`.
- R8: A completion (`cons_done_valid`) on an owned slot sets that slot's status word, at a single edge, to bit 31 = 0 and bits 30:0 = `cons_done_status`. The control and buffer words are left unchanged.
- R9: A completion aimed at a slot whose status bit 31 is 0 has no effect on that slot.
- R10: Word 3 of slot i reads RING_BASE + ((i+1) mod 16) * 16, so the last slot links back to RING_BASE. Read select encoding: 0 = status, 1 = control, 2 = buffer address, 3 = link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sub_valid | input | 1 | Frame offered by software |
| sub_ready | output | 1 | At least one descriptor is free |
| sub_len | input | 11 | Frame length in bytes |
| sub_addr | input | 32 | Frame buffer address |
| poll_demand | output | 1 | One-cycle transmit poll strobe |
| cons_rd_idx | input | 4 | Descriptor to read |
| cons_rd_sel | input | 2 | Word to read (0 status, 1 control, 2 buffer, 3 link) |
| cons_rd_data | output | 32 | Selected descriptor word |
| cons_done_valid | input | 1 | Completion write strobe |
| cons_done_idx | input | 4 | Descriptor being completed |
| cons_done_status | input | 31 | Completion status bits 30:0 |

## Verification
The checker assumes that reset is held for at least one edge before any property is sampled. It also assumes that the consumer completes only slots it has been handed: a completion on a free slot is allowed but must leave the ownership mask alone. The ownership-count property relies on a submit and a completion never naming the same slot in one cycle. That holds because a submit picks only free slots and a completion acts only on owned ones. The stimulus drives every input on the falling edge and never holds `sub_valid` across a cycle in which it reads back, so each accept is a single, deliberate edge.

// File: rtl/txring_pkg.sv
package txring_pkg;
   localparam int unsigned WORD_W      = 32;
   localparam int unsigned OWN_BIT     = 31;
   localparam logic [31:0] CTRL_FRAME  = 32'hE100_0000;
   localparam logic [31:0] CTRL_IDLE   = 32'h0100_0000;
   localparam logic [31:0] STAT_OWNED  = 32'h8000_0000;

   typedef enum logic [1:0] {
      WSEL_STATUS = 2'd0,
      WSEL_CTRL   = 2'd1,
      WSEL_BUF    = 2'd2,
      WSEL_LINK   = 2'd3
   } word_sel_e;
endpackage

// File: rtl/txring_slot.sv
module txring_slot
   import txring_pkg::*;
(
   input  logic              clk,
   input  logic              rst,
   input  logic              fill,
   input  logic [WORD_W-1:0] fill_ctrl,
   input  logic [WORD_W-1:0] fill_buf,
   input  logic              done,
   input  logic [WORD_W-2:0] done_status,
   output logic [WORD_W-1:0] status_q,
   output logic [WORD_W-1:0] ctrl_q,
   output logic [WORD_W-1:0] buf_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         status_q <= '0;
         ctrl_q   <= CTRL_IDLE;
         buf_q    <= '0;
      end else if (fill) begin
         status_q <= STAT_OWNED;
         ctrl_q   <= fill_ctrl;
         buf_q    <= fill_buf;
      end else if (done && status_q[OWN_BIT]) begin
         status_q <= {1'b0, done_status};
      end
   end
endmodule

// File: rtl/txring_pick.sv
module txring_pick #(
   parameter int unsigned SLOTS = 16,
   localparam int unsigned IDX_W = $clog2(SLOTS)
) (
   input  logic [SLOTS-1:0] owned,
   input  logic [IDX_W-1:0] start,
   output logic [IDX_W-1:0] pick,
   output logic             any_free
);
   always_comb begin
      pick     = start;
      any_free = 1'b0;
      for (int k = SLOTS - 1; k >= 0; k--) begin
         logic [IDX_W-1:0] cand;
         cand = start + IDX_W'(k);
         if (!owned[cand]) begin
            pick     = cand;
            any_free = 1'b1;
         end
      end
   end
endmodule

// File: rtl/txring_mgr.sv
module txring_mgr
   import txring_pkg::*;
#(
   parameter int unsigned SLOTS      = 16,
   parameter int unsigned LEN_W      = 11,
   parameter int unsigned MIN_LEN    = 60,
   parameter int unsigned DESC_BYTES = 16,
   parameter logic [31:0] RING_BASE  = 32'h0000_1000,
   parameter bit          PAD_EN     = 1'b1,
   localparam int unsigned IDX_W     = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sub_valid,
   output logic              sub_ready,
   input  logic [LEN_W-1:0]  sub_len,
   input  logic [31:0]       sub_addr,
   output logic              poll_demand,
   input  logic [IDX_W-1:0]  cons_rd_idx,
   input  logic [1:0]        cons_rd_sel,
   output logic [31:0]       cons_rd_data,
   input  logic              cons_done_valid,
   input  logic [IDX_W-1:0]  cons_done_idx,
   input  logic [30:0]       cons_done_status
);
   if (SLOTS < 2 || (1 << IDX_W) != SLOTS)
      $error("txring_mgr: SLOTS must be a power of two, at least 2");
   if (LEN_W > 24)
      $error("txring_mgr: LEN_W must fit below the control flags");
   if (MIN_LEN >= (1 << LEN_W))
      $error("txring_mgr: MIN_LEN does not fit in LEN_W bits");

   logic [SLOTS-1:0]  own_mask;
   logic [IDX_W-1:0]  fill_ptr_q;
   logic [IDX_W-1:0]  pick_idx;
   logic              any_free;
   logic              accept;
   logic [LEN_W-1:0]  fill_len;
   logic [31:0]       fill_ctrl;
   logic [31:0]       st_w [SLOTS];
   logic [31:0]       ct_w [SLOTS];
   logic [31:0]       bf_w [SLOTS];

   txring_pick #(.SLOTS(SLOTS)) u_pick (
      .owned    (own_mask),
      .start    (fill_ptr_q),
      .pick     (pick_idx),
      .any_free (any_free)
   );

   assign sub_ready = any_free;
   assign accept    = sub_valid && any_free;

   if (PAD_EN) begin : g_pad
      assign fill_len = (sub_len < LEN_W'(MIN_LEN)) ? LEN_W'(MIN_LEN) : sub_len;
   end else begin : g_nopad
      assign fill_len = sub_len;
   end

   assign fill_ctrl = CTRL_FRAME | {{(32-LEN_W){1'b0}}, fill_len};

   for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      txring_slot u_slot (
         .clk         (clk),
         .rst         (rst),
         .fill        (accept && (pick_idx == IDX_W'(i))),
         .fill_ctrl   (fill_ctrl),
         .fill_buf    (sub_addr),
         .done        (cons_done_valid && (cons_done_idx == IDX_W'(i))),
         .done_status (cons_done_status),
         .status_q    (st_w[i]),
         .ctrl_q      (ct_w[i]),
         .buf_q       (bf_w[i])
      );
      assign own_mask[i] = st_w[i][OWN_BIT];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         fill_ptr_q  <= '0;
         poll_demand <= 1'b0;
      end else begin
         poll_demand <= accept;
         if (accept)
            fill_ptr_q <= pick_idx + 1'b1;
      end
   end

   logic [IDX_W-1:0] link_idx;
   assign link_idx = cons_rd_idx + 1'b1;

   always_comb begin
      case (word_sel_e'(cons_rd_sel))
         WSEL_STATUS: cons_rd_data = st_w[cons_rd_idx];
         WSEL_CTRL:   cons_rd_data = ct_w[cons_rd_idx];
         WSEL_BUF:    cons_rd_data = bf_w[cons_rd_idx];
         default:     cons_rd_data = RING_BASE + 32'(link_idx) * 32'(DESC_BYTES);
      endcase
   end
endmodule

// File: rtl/txring_mgr_chk.sv
module txring_mgr_chk #(
   parameter int unsigned SLOTS = 16,
   localparam int unsigned IDX_W = $clog2(SLOTS)
) (
   input logic             clk,
   input logic             rst,
   input logic             sub_valid,
   input logic             sub_ready,
   input logic             poll_demand,
   input logic             cons_done_valid,
   input logic [IDX_W-1:0] cons_done_idx,
   input logic [SLOTS-1:0] own_mask
);
   logic acc;
   assign acc = sub_valid && sub_ready;

   assert_poll_after_accept_R4: assert property (@(posedge clk) disable iff (rst)
      acc |=> poll_demand);

   assert_no_stray_poll_R4: assert property (@(posedge clk) disable iff (rst)
      !acc |=> !poll_demand);

   assert_accept_claims_one_R2: assert property (@(posedge clk) disable iff (rst)
      (acc && !cons_done_valid) |=>
         ($countones(own_mask) == $countones($past(own_mask)) + 1));

   assert_full_blocks_R7: assert property (@(posedge clk) disable iff (rst)
      (!sub_ready && !cons_done_valid) |=> $stable(own_mask));

   assert_done_releases_R8: assert property (@(posedge clk) disable iff (rst)
      (cons_done_valid && own_mask[cons_done_idx]) |=> !own_mask[$past(cons_done_idx)]);

   assert_done_ignored_R9: assert property (@(posedge clk) disable iff (rst)
      (cons_done_valid && !own_mask[cons_done_idx] && !acc) |=> $stable(own_mask));
endmodule

bind txring_mgr txring_mgr_chk #(.SLOTS(SLOTS)) u_chk (
   .clk             (clk),
   .rst             (rst),
   .sub_valid       (sub_valid),
   .sub_ready       (sub_ready),
   .poll_demand     (poll_demand),
   .cons_done_valid (cons_done_valid),
   .cons_done_idx   (cons_done_idx),
   .own_mask        (own_mask)
);

// File: tb/test_txring_mgr.sv
module test_txring_mgr;
   localparam logic [31:0] BASE = 32'h0000_1000;
   localparam int NVEC = 8;
   // {len[10:0], addr[31:0], slot[3:0], expected control word}
   localparam logic [78:0] VEC [NVEC] = '{
      {11'd0,    32'hA000_0000, 4'd0, 32'hE100_003C},
      {11'd1,    32'hA000_0600, 4'd1, 32'hE100_003C},
      {11'd59,   32'hA000_0C00, 4'd2, 32'hE100_003C},
      {11'd60,   32'hA000_1200, 4'd3, 32'hE100_003C},
      {11'd61,   32'hA000_1800, 4'd4, 32'hE100_003D},
      {11'd1514, 32'hA000_1E00, 4'd5, 32'hE100_05EA},
      {11'd2047, 32'hA000_2400, 4'd6, 32'hE100_07FF},
      {11'd100,  32'hA000_2A00, 4'd7, 32'hE100_0064}
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        sub_valid = 1'b0;
   logic        sub_ready;
   logic [10:0] sub_len = '0;
   logic [31:0] sub_addr = '0;
   logic        poll_demand;
   logic [3:0]  cons_rd_idx = '0;
   logic [1:0]  cons_rd_sel = '0;
   logic [31:0] cons_rd_data;
   logic        cons_done_valid = 1'b0;
   logic [3:0]  cons_done_idx = '0;
   logic [30:0] cons_done_status = '0;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   txring_mgr i_txring_mgr (
      .clk(clk), .rst(rst), .sub_valid(sub_valid), .sub_ready(sub_ready),
      .sub_len(sub_len), .sub_addr(sub_addr), .poll_demand(poll_demand),
      .cons_rd_idx(cons_rd_idx), .cons_rd_sel(cons_rd_sel), .cons_rd_data(cons_rd_data),
      .cons_done_valid(cons_done_valid), .cons_done_idx(cons_done_idx),
      .cons_done_status(cons_done_status)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic rd(input logic [3:0] idx, input logic [1:0] sel, output logic [31:0] val);
      cons_rd_idx = idx;
      cons_rd_sel = sel;
      #1;
      val = cons_rd_data;
   endtask

   // Offer one frame for one edge; on return sits at the next falling edge.
   task automatic submit(input logic [10:0] len, input logic [31:0] addr, output logic poll);
      @(negedge clk);
      sub_valid = 1'b1;
      sub_len   = len;
      sub_addr  = addr;
      @(negedge clk);
      sub_valid = 1'b0;
      poll = poll_demand;
   endtask

   task automatic complete(input logic [3:0] idx, input logic [30:0] st);
      @(negedge clk);
      cons_done_valid  = 1'b1;
      cons_done_idx    = idx;
      cons_done_status = st;
      @(negedge clk);
      cons_done_valid  = 1'b0;
   endtask

   initial begin
      logic [31:0] v;
      logic p;
      repeat (3) @(negedge clk);
      rst = 1'b0;

      // R1 reset state
      rd(4'd5, 2'd0, v); check("R1 status", v, 32'h0);
      rd(4'd5, 2'd1, v); check("R1 ctrl", v, 32'h0100_0000);
      rd(4'd5, 2'd2, v); check("R1 buf", v, 32'h0);
      check("R1 ready", {31'd0, sub_ready}, 32'd1);
      check("R1 poll", {31'd0, poll_demand}, 32'd0);

      // R10 link words
      rd(4'd0, 2'd3, v);  check("R10 link0", v, BASE + 32'd16);
      rd(4'd15, 2'd3, v); check("R10 link15", v, BASE);

      // Table walk: R2 R3 R4 R5
      for (int i = 0; i < NVEC; i++) begin
         logic [3:0] s;
         s = VEC[i][35:32];
         submit(VEC[i][78:68], VEC[i][67:36], p);
         check("R4 poll pulse", {31'd0, p}, 32'd1);
         rd(s, 2'd0, v); check("R2 R5 status", v, 32'h8000_0000);
         rd(s, 2'd1, v); check("R2 R3 ctrl", v, VEC[i][31:0]);
         rd(s, 2'd2, v); check("R2 buf", v, VEC[i][67:36]);
         @(negedge clk);
         check("R4 poll single", {31'd0, poll_demand}, 32'd0);
      end

      // Fill remaining slots 8..15 (R5)
      for (int i = 8; i < 16; i++) begin
         submit(11'd200, 32'hB000_0000 + 32'(i), p);
         rd(4'(i), 2'd2, v); check("R5 order", v, 32'hB000_0000 + 32'(i));
      end

      // R7 full ring
      check("R7 ready low", {31'd0, sub_ready}, 32'd0);
      submit(11'd300, 32'hDEAD_0000, p);
      check("R7 no poll", {31'd0, p}, 32'd0);
      rd(4'd0, 2'd2, v); check("R7 slot0 buf kept", v, 32'hA000_0000);
      rd(4'd0, 2'd1, v); check("R7 slot0 ctrl kept", v, 32'hE100_003C);

      // R8 completion
      complete(4'd3, 31'h0000_1234);
      rd(4'd3, 2'd0, v); check("R8 status", v, 32'h0000_1234);
      rd(4'd3, 2'd1, v); check("R8 ctrl kept", v, 32'hE100_003C);
      rd(4'd3, 2'd2, v); check("R8 buf kept", v, 32'hA000_1200);
      check("R8 ready back", {31'd0, sub_ready}, 32'd1);

      // R9 completion on free slot ignored
      complete(4'd3, 31'h7FFF_FFFF);
      rd(4'd3, 2'd0, v); check("R9 ignored", v, 32'h0000_1234);

      // R6 skip owned slots
      complete(4'd9, 31'h1);
      submit(11'd70, 32'hC000_0003, p);
      rd(4'd3, 2'd2, v); check("R6 takes slot3", v, 32'hC000_0003);
      rd(4'd3, 2'd1, v); check("R6 ctrl slot3", v, 32'hE100_0046);
      submit(11'd80, 32'hC000_0009, p);
      rd(4'd9, 2'd2, v); check("R6 takes slot9", v, 32'hC000_0009);
      complete(4'd0, 31'h2);
      submit(11'd90, 32'hC000_0000, p);
      rd(4'd0, 2'd2, v); check("R6 wraps to slot0", v, 32'hC000_0000);
      check("R7 full again", {31'd0, sub_ready}, 32'd0);

      // R1 mid-run reset, then R5 restart at slot 0
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      rd(4'd9, 2'd0, v); check("R1 rerst status", v, 32'h0);
      rd(4'd9, 2'd1, v); check("R1 rerst ctrl", v, 32'h0100_0000);
      check("R1 rerst ready", {31'd0, sub_ready}, 32'd1);
      submit(11'd64, 32'hE000_0000, p);
      rd(4'd0, 2'd2, v); check("R5 restart slot0", v, 32'hE000_0000);
      rd(4'd1, 2'd0, v); check("R5 slot1 idle", v, 32'h0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule